// File: doc/BRIEF.md
# Wide Timebase Counter with Snapshot and Preset

This block is a free-running 64-bit up-counter that serves as the system time reference. Its input clock passes through a programmable prescaler, so the count advances once every N+1 clocks. Software reaches it through a 32-bit register port that uses a one-cycle request and returns read data one cycle later.

A 32-bit port cannot read a 64-bit value in one access, and the two halves can disagree if they are read one after the other. To avoid this, a control write with the strobe bit set copies all 64 counter bits into a pair of snapshot words in a single edge. Software then reads both words at leisure. With the mode bit also set, the same strobe does the reverse: it overwrites the counter with the 64-bit value held in two preset words. Reading a snapshot, writing it into the preset pair and then loading it puts the count back to the saved value.

Top module: `wide_timebase`

## Requirements
- R1: After reset, the counter, the preset pair, the snapshot pair, the divider field and the mode bit are all zero, and rvalid_o is low.
- R2: With divider value N in control bits [31:16], the count increments exactly once every N+1 clocks. N = 0 gives one increment per clock. A new divider is stored at the write edge.
- R3: The counter is 64 bits wide. A carry passes from the low word into the high word, and the count wraps from all ones to zero.
- R4: A control write with bit 0 = 1 and bit 1 = 0 copies the count as it stood in the write cycle into the snapshot pair. The snapshot pair then holds that value until the next such write.
- R5: Taking a snapshot does not disturb counting: no tick is lost or added.
- R6: A control write with bit 0 = 1 and bit 1 = 1 replaces the count with the preset pair at the write edge. The load wins over any increment due on that edge, and the prescaler phase restarts, so the loaded value holds for N+1 clocks.
- R7: Control bit 0 is a strobe and always reads back as 0. Bit 1 and the divider field read back as last written, and all other control bits read 0.
- R8: Writes to the live count words and to the snapshot words are ignored.
- R9: Word addresses on addr_i are: 0 control, 1 count low, 2 count high, 3 snapshot low, 4 snapshot high, 5 preset low, 6 preset high, 7 reads zero. A read request (req_i=1, we_i=0) raises rvalid_o for one cycle on the next clock, with rdata_o carrying the register value from the request cycle.
- R10: Writing values read from the snapshot pair into the preset pair and then loading them restores the count to exactly the snapshot value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counter and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
Read data is due on the first clock after the request cycle. It reflects the count as it stood in the request cycle. A snapshot holds the count from the cycle of the control write. A loaded value is what a read issued on the cycle right after the load returns. The bench drives and samples on falling edges and runs a behavioural model that makes the same per-edge decisions. It compares every read response in the cycle its rvalid_o is due. Restore is also checked against values captured from the bus itself.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  localparam int ADDR_W   = 3;
  localparam int GO_BIT   = 0;
  localparam int MODE_BIT = 1;
  localparam int DIV_LSB  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SNAP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_SNAP_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 3'd5;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 3'd6;
endpackage

// File: rtl/wtb_prescaler.sv
module wtb_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  // >= so a divider lowered below the current phase ends the period at once
  assign tick_o = (phase_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (tick_o)    phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/wtb_counter.sv
module wtb_counter #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 2,
  localparam int CNT_W = WORD_W * WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [WORDS-1:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       word_q <= '0;
      else if (load_i)   word_q <= load_val_i[g*WORD_W +: WORD_W];
      else if (carry[g]) word_q <= word_q + 1'b1;
    end

    assign count_o[g*WORD_W +: WORD_W] = word_q;

    if (g < WORDS-1) begin : g_ripple
      assign carry[g+1] = carry[g] & (&word_q);
    end
  end
endmodule

// File: rtl/wtb_regfile.sv
module wtb_regfile
  import wtb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [2*DATA_W-1:0] count_i,
  output logic [DIV_W-1:0]    div_o,
  output logic                load_o,
  output logic [2*DATA_W-1:0] preset_o,
  output logic [2*DATA_W-1:0] snap_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              wr, rd, ctrl_wr, go, snap_stb;
  logic [DIV_W-1:0]  div_q;
  logic              mode_q;
  logic [CNT_W-1:0]  preset_q, snap_q;
  logic [DATA_W-1:0] ctrl_rd, rd_mux;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign ctrl_wr  = wr && (addr_i == A_CTRL);
  assign go       = ctrl_wr && wdata_i[GO_BIT];
  assign load_o   = go && wdata_i[MODE_BIT];
  assign snap_stb = go && !wdata_i[MODE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      mode_q <= 1'b0;
    end else if (ctrl_wr) begin
      div_q  <= wdata_i[DIV_LSB +: DIV_W];
      mode_q <= wdata_i[MODE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_q <= '0;
    end else if (wr) begin
      if (addr_i == A_PRE_LO) preset_q[DATA_W-1:0]     <= wdata_i;
      if (addr_i == A_PRE_HI) preset_q[CNT_W-1:DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       snap_q <= '0;
    else if (snap_stb) snap_q <= count_i;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[DIV_LSB +: DIV_W] = div_q;
    ctrl_rd[MODE_BIT] = mode_q;
  end

  always_comb begin
    case (addr_i)
      A_CTRL:    rd_mux = ctrl_rd;
      A_CNT_LO:  rd_mux = count_i[DATA_W-1:0];
      A_CNT_HI:  rd_mux = count_i[CNT_W-1:DATA_W];
      A_SNAP_LO: rd_mux = snap_q[DATA_W-1:0];
      A_SNAP_HI: rd_mux = snap_q[CNT_W-1:DATA_W];
      A_PRE_LO:  rd_mux = preset_q[DATA_W-1:0];
      A_PRE_HI:  rd_mux = preset_q[CNT_W-1:DATA_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  assign div_o    = div_q;
  assign preset_o = preset_q;
  assign snap_o   = snap_q;
endmodule

// File: rtl/wide_timebase.sv
module wide_timebase
  import wtb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DIV_W-1:0] div_w;
  logic             load_w, tick_w;
  logic [CNT_W-1:0] count_w, preset_w, snap_w;

  wtb_regfile #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .count_i (count_w),
    .div_o   (div_w),
    .load_o  (load_w),
    .preset_o(preset_w),
    .snap_o  (snap_w),
    .rdata_o, .rvalid_o
  );

  wtb_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni,
    .div_i    (div_w),
    .restart_i(load_w),
    .tick_o   (tick_w)
  );

  wtb_counter #(.WORD_W(DATA_W), .WORDS(2)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i     (tick_w),
    .load_i    (load_w),
    .load_val_i(preset_w),
    .count_o   (count_w)
  );
endmodule

// File: rtl/wtb_checker.sv
module wtb_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic             go_bit_i,
  input logic             mode_bit_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] snap_i,
  input logic             rvalid_i
);
  logic ctl_go, ld_go, sn_go, rd_req;
  assign ctl_go = req_i && we_i && (addr_i == 3'd0) && go_bit_i;
  assign ld_go  = ctl_go && mode_bit_i;
  assign sn_go  = ctl_go && !mode_bit_i;
  assign rd_req = req_i && !we_i;

  // R6
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_go |=> count_i == $past(preset_i));

  // R4
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sn_go |=> snap_i == $past(count_i));

  // R4
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sn_go |=> $stable(snap_i));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_go |=> (count_i == $past(count_i)) || (count_i == $past(count_i) + CNT_W'(1)));

  // R9
  rvalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_i);

  // R9
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_i);
endmodule

bind wide_timebase wtb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
  .go_bit_i  (wdata_i[0]),
  .mode_bit_i(wdata_i[1]),
  .count_i   (count_w),
  .preset_i  (preset_w),
  .snap_i    (snap_w),
  .rvalid_i  (rvalid_o)
);

// File: tb/wide_timebase_bench.sv
`timescale 1ns/1ps
module wide_timebase_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  always #2.5 clk = ~clk;

  wide_timebase u_wide_timebase (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int n_vec = 0, n_fail = 0, cyc = 0;
  string cur_tag = "";

  // behavioural reference model
  longint unsigned m_cnt, m_pre, m_snap;
  int unsigned     m_div, m_ph;
  bit              m_mode, m_rvalid, m_ld, m_sn;
  logic [31:0]     m_rdata;
  string           m_tag;

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return {m_div[15:0], 14'd0, m_mode, 1'b0};
      3'd1: return m_cnt[31:0];
      3'd2: return m_cnt[63:32];
      3'd3: return m_snap[31:0];
      3'd4: return m_snap[63:32];
      3'd5: return m_pre[31:0];
      3'd6: return m_pre[63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_snap = 0; m_div = 0; m_ph = 0;
      m_mode = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      m_rvalid = req && !we;
      if (m_rvalid) begin m_rdata = mread(addr); m_tag = cur_tag; end
      m_ld = req && we && addr == 3'd0 && wdata[0] && wdata[1];
      m_sn = req && we && addr == 3'd0 && wdata[0] && !wdata[1];
      if (m_sn) m_snap = m_cnt;
      if (m_ld) begin m_cnt = m_pre; m_ph = 0; end
      else if (m_ph >= m_div) begin m_ph = 0; m_cnt = m_cnt + 1; end
      else m_ph = m_ph + 1;
      if (req && we) begin
        if (addr == 3'd0) begin m_div = wdata[31:16]; m_mode = wdata[1]; end
        if (addr == 3'd5) m_pre[31:0]  = wdata;
        if (addr == 3'd6) m_pre[63:32] = wdata;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid !== m_rvalid) begin
        n_fail++;
        $display("FAIL R9: rvalid_o got %b exp %b", rvalid, m_rvalid);
      end else if (m_rvalid) begin
        n_vec++;
        if (rdata !== m_rdata) begin
          n_fail++;
          $display("FAIL %s: rdata got %h exp %h", m_tag, rdata, m_rdata);
        end
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input string tag);
    cur_tag = tag; req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic direct(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles exp < 50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  logic [31:0] sv_lo, sv_hi;

  initial begin
    idle(3);
    direct("R1 rvalid in reset", {31'd0, rvalid}, 32'd0);
    direct("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    idle(1);
    bus_rd(3'd0, "R1 ctrl");
    bus_rd(3'd3, "R1 snap lo");
    bus_rd(3'd4, "R1 snap hi");
    bus_rd(3'd5, "R1 preset lo");
    bus_rd(3'd6, "R1 preset hi");
    bus_rd(3'd7, "R9 unmapped");
    for (int i = 0; i < 4; i++) bus_rd(3'd1, "R2 div0 count lo");

    // R8: live and snapshot words ignore writes
    bus_wr(3'd1, 32'hDEAD_BEEF);
    bus_wr(3'd2, 32'h1234_5678);
    bus_wr(3'd3, 32'hCAFE_F00D);
    bus_rd(3'd1, "R8 count lo after write");
    bus_rd(3'd2, "R8 count hi after write");
    bus_rd(3'd3, "R8 snap lo after write");

    // R2, R7: divider 3
    bus_wr(3'd0, 32'h0003_0000);
    bus_rd(3'd0, "R7 ctrl readback div");
    for (int i = 0; i < 10; i++) bus_rd(3'd1, "R2 div3 count lo");
    idle(2);
    for (int i = 0; i < 5; i++) bus_rd(3'd1, "R2 div3 spaced count lo");

    // R6, R3: load near top, watch full wrap
    bus_wr(3'd5, 32'hFFFF_FFFA);
    bus_wr(3'd6, 32'hFFFF_FFFF);
    bus_wr(3'd0, 32'h0003_0003);
    bus_rd(3'd0, "R7 ctrl strobe reads 0");
    for (int i = 0; i < 6; i++) bus_rd(3'd1, "R6 count lo after load");
    for (int i = 0; i < 20; i++) begin
      bus_rd(3'd1, "R3 wrap count lo");
      bus_rd(3'd2, "R3 wrap count hi");
    end

    // R3: carry low to high, divider 0
    bus_wr(3'd5, 32'hFFFF_FFFE);
    bus_wr(3'd6, 32'h0000_0000);
    bus_wr(3'd0, 32'h0000_0003);
    bus_rd(3'd1, "R6 load priority lo");
    for (int i = 0; i < 4; i++) begin
      bus_rd(3'd1, "R3 carry count lo");
      bus_rd(3'd2, "R3 carry count hi");
    end

    // R4, R5: snapshot
    idle(5);
    bus_wr(3'd0, 32'h0000_0001);
    bus_rd(3'd0, "R7 ctrl after snapshot");
    idle(7);
    bus_rd(3'd3, "R4 snap lo");
    bus_rd(3'd4, "R4 snap hi");
    bus_rd(3'd1, "R5 count lo after snap");
    bus_rd(3'd2, "R5 count hi after snap");
    bus_rd(3'd3, "R4 snap lo held");

    // R10: restore through the bus
    idle(20);
    bus_rd(3'd3, "R10 read snap lo");
    sv_lo = rdata;
    bus_rd(3'd4, "R10 read snap hi");
    sv_hi = rdata;
    bus_wr(3'd5, sv_lo);
    bus_wr(3'd6, sv_hi);
    bus_wr(3'd0, 32'h0000_0003);
    bus_rd(3'd1, "R10 restored lo");
    direct("R10 restored lo direct", rdata, sv_lo);
    bus_rd(3'd2, "R10 restored hi");
    direct("R10 restored hi direct", rdata, sv_hi);

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule